// File: doc/BRIEF.md
# Burst Read Wait-State Sequencer

This block runs four-word burst reads from a cache or memory array onto a processor-side bus. An idle sequencer takes a request together with a byte start address and a two-bit timing profile. It then returns four 32-bit words from the aligned 16-byte line that holds the start address. The first word arrives after a leadoff delay. Each of the other three arrives after a shorter per-word delay. The sequencer produces the three follow-on addresses itself, in interleaved order, so only the first word pays for an address phase.

Each word comes with a one-clock ready strobe, the address of that word and its data. The fourth word also raises a done strobe. The memory array is modelled as a registered lookup whose content is a fixed function of the word address. The timing profile is captured when a request is accepted and stays fixed for that burst. While a burst is running, the block reports busy and ignores new requests.

Top module: `burst_seq`

## Requirements
- R1: After reset, `busy`, `rdy` and `done` are all low, and they stay low until a request is accepted.
- R2: A request is accepted on a rising edge where `req` is high and the sequencer is idle. Each accepted request yields exactly four `rdy` pulses, each one clock long. `done` is high together with the fourth pulse and at no other time.
- R3: The profile select encodes the latencies as leadoff-follow: 0 gives 2-1-1-1, 1 gives 3-1-1-1, 2 gives 2-2-2-2 and 3 gives 3-2-2-2. The first `rdy` is high in the cycle that begins leadoff rising edges after the accepting edge. Each later `rdy` is high follow edges after the previous one.
- R4: Let S be the start address. Word n (n = 0..3) is returned at byte address {S[15:4], S[3:2] XOR n, 2'b00}, and `rd_addr` shows that address while `rdy` is high.
- R5: While `rdy` is high, `rd_data` equals {~A, A}, where A is the 16-bit byte address currently shown on `rd_addr`.
- R6: `busy` is high from the accepting edge up to, but not including, the edge that raises the fourth `rdy`. A request raised while `busy` is high is ignored: the burst in progress keeps its addresses and timing, and no additional `rdy` pulses follow it.
- R7: The profile select is sampled only at the accepting edge. Changing it during a burst has no effect on that burst's timing.
- R8: Bits [1:0] of the start address are ignored. Word addresses are always 4-byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Burst request, sampled while idle |
| start_addr | input | 16 | Byte address of the first word |
| prof_sel | input | 2 | Timing profile select |
| busy | output | 1 | Burst in progress; requests are ignored |
| rdy | output | 1 | One-clock strobe marking a valid word |
| done | output | 1 | Strobe together with the fourth word |
| rd_addr | output | 16 | Byte address of the word being delivered |
| rd_data | output | 32 | Data of the word being delivered |

## Verification
The bench aims at three kinds of error:
- **Latency counting.** It runs every profile against each of the four start positions within a line. A counter that is off by one would shift `rdy` by a whole cycle, and the per-cycle comparison shows this.
- **Reloads during a burst.** During a burst it raises new requests and changes the profile select. A design that reloaded its start address mid-burst, or latched the select late, would deliver wrong addresses or stretch the gaps between words.
- **End of a burst.** It checks that no fifth `rdy` appears and that `busy` falls on the same edge as the fourth word. It also sets the low address bits to non-zero values, so a design that leaked them into `rd_addr` would return unaligned addresses and data that do not match.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int DATA_W = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Content model of the array: the word at byte address a holds {~a, a}
    function automatic logic [DATA_W-1:0] line_word(input logic [15:0] a);
        return {~a, a};
    endfunction

endpackage

// File: rtl/burst_profile_dec.sv
module burst_profile_dec #(
    parameter int CW          = 2,
    parameter int LEAD_SHORT  = 2,
    parameter int LEAD_LONG   = 3,
    parameter int FOLLOW_FAST = 1,
    parameter int FOLLOW_SLOW = 2
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] lead,
    output logic [CW-1:0] follow
);
    // bit 0 picks the leadoff, bit 1 picks the per-word latency
    always_comb begin
        lead   = sel[0] ? CW'(LEAD_LONG)   : CW'(LEAD_SHORT);
        follow = sel[1] ? CW'(FOLLOW_SLOW) : CW'(FOLLOW_FAST);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int AW = 16
) (
    input  logic [AW-5:0] line_base,
    input  logic [1:0]    first_word,
    input  logic [1:0]    beat,
    output logic [AW-1:0] word_addr
);
    // interleaved order: the beat number toggles bits of the starting word index
    always_comb begin
        word_addr = {line_base, first_word ^ beat, 2'b00};
    end
endmodule

// File: rtl/burst_line_rom.sv
module burst_line_rom
    import burst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data_q
);
    logic [DATA_W-1:0] rd_data_d;

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) begin
            rd_data_d = line_word(rd_addr[15:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [AW-1:0]     start_addr,
    input  logic [1:0]        prof_sel,
    output logic              busy,
    output logic              rdy,
    output logic              done,
    output logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int LINE_W = AW - 4;

    typedef struct packed {
        seq_state_e      st;
        logic [CW-1:0]   cnt;
        logic [1:0]      beat;
        logic [LINE_W-1:0] base;
        logic [1:0]      w0;
        logic [CW-1:0]   fol;
        logic            rdy;
        logic            done;
        logic [AW-1:0]   addr;
    } seq_t;

    seq_t s_d, s_q;

    logic [CW-1:0] lead_lat;
    logic [CW-1:0] fol_lat;
    logic [AW-1:0] cur_addr;
    logic          emit;
    logic [1:0]    unused_lo;

    assign unused_lo = start_addr[1:0];

    burst_profile_dec #(.CW(CW)) u_prof (
        .sel    (prof_sel),
        .lead   (lead_lat),
        .follow (fol_lat)
    );

    burst_addr_gen #(.AW(AW)) u_agen (
        .line_base  (s_q.base),
        .first_word (s_q.w0),
        .beat       (s_q.beat),
        .word_addr  (cur_addr)
    );

    burst_line_rom #(.AW(AW)) u_rom (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (emit),
        .rd_addr   (cur_addr),
        .rd_data_q (rd_data)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rdy  = 1'b0;
        s_d.done = 1'b0;
        emit     = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req) begin
                    s_d.st   = ST_RUN;
                    s_d.cnt  = lead_lat - CW'(1);
                    s_d.beat = 2'd0;
                    s_d.base = start_addr[AW-1:4];
                    s_d.w0   = start_addr[3:2];
                    s_d.fol  = fol_lat;
                end
            end
            default: begin
                if (s_q.cnt == '0) begin
                    emit     = 1'b1;
                    s_d.rdy  = 1'b1;
                    s_d.addr = cur_addr;
                    s_d.beat = s_q.beat + 2'd1;
                    s_d.cnt  = s_q.fol - CW'(1);
                    if (s_q.beat == 2'd3) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st == ST_RUN);
    assign rdy     = s_q.rdy;
    assign done    = s_q.done;
    assign rd_addr = s_q.addr;

    // R2
    done_has_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rdy);

    // R2
    rdy_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(busy));

    // R4
    rdy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (rd_addr[AW-1:4] == s_q.base && rd_addr[1:0] == 2'b00));

    // R6
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(s_q.base) && $stable(s_q.w0) && $stable(s_q.fol));

    // R4
    last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_addr[3:2] == (s_q.w0 ^ 2'd3));

    // R5
    data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> rd_data == line_word(rd_addr[15:0]));
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] start_addr = '0;
    logic [1:0]  prof_sel = '0;
    logic        busy, rdy, done;
    logic [15:0] rd_addr;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .start_addr(start_addr),
        .prof_sel(prof_sel), .busy(busy), .rdy(rdy), .done(done),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int lead_of(input logic [1:0] s);
        return s[0] ? 3 : 2;
    endfunction

    function automatic int fol_of(input logic [1:0] s);
        return s[1] ? 2 : 1;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [15:0] s, input int n);
        return {s[15:4], s[3:2] ^ n[1:0], 2'b00};
    endfunction

    function automatic logic [31:0] exp_data(input logic [15:0] a);
        return {~a, a};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // one burst: accept, then compare every cycle until after the fourth word
    task automatic run_burst(input logic [15:0] sa, input logic [1:0] sel, input bit disturb);
        int L, F, last, n;
        L = lead_of(sel);
        F = fol_of(sel);
        last = L + 3 * F;
        n = 0;
        @(negedge clk);
        req = 1'b1;
        start_addr = sa;
        prof_sel = sel;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int c = 1; c <= last + 1; c++) begin
            bit exp_r;
            @(posedge clk);
            @(negedge clk);
            exp_r = (c >= L) && (c <= last) && ((c - L) % F == 0);
            chk(rdy == exp_r, "R3 rdy timing", 32'(rdy), 32'(exp_r));
            chk(busy == (c < last), "R6 busy window", 32'(busy), 32'(c < last));
            chk(done == (c == last), "R2 done on fourth word", 32'(done), 32'(c == last));
            if (rdy && exp_r) begin
                chk(rd_addr == exp_addr(sa, n), "R4 R8 word address", 32'(rd_addr), 32'(exp_addr(sa, n)));
                chk(rd_data == exp_data(exp_addr(sa, n)), "R5 word data", rd_data, exp_data(exp_addr(sa, n)));
                n++;
            end
            if (disturb && c < last) begin
                // R6 R7: new requests and profile changes mid-burst must not matter
                req = 1'($urandom);
                start_addr = 16'($urandom);
                prof_sel = 2'($urandom);
            end else begin
                req = 1'b0;
            end
        end
        chk(n == 4, "R2 four words per burst", 32'(n), 32'd4);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #20;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy at reset", 32'(busy), 32'd0);
        chk(rdy == 1'b0, "R1 rdy at reset", 32'(rdy), 32'd0);
        chk(done == 1'b0, "R1 done at reset", 32'(done), 32'd0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !rdy, "R1 idle after reset", {30'd0, busy, rdy}, 32'd0);
        end
        // directed: every profile from every start word, low bits set (R8)
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 4; w++) begin
                run_burst({12'h3A5, w[1:0], 2'b11}, p[1:0], 1'b0);
            end
        end
        // directed: disturbed bursts with slowest and fastest profiles (R6, R7)
        run_burst(16'hFFFE, 2'd3, 1'b1);
        run_burst(16'h0009, 2'd0, 1'b1);
        // random mix
        for (int i = 0; i < 60; i++) begin
            run_burst(16'($urandom), 2'($urandom), 1'($urandom));
            repeat (int'($urandom % 3)) @(negedge clk);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule